// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream for a four-beat burst into a synchronous memory. When a load strobe is sampled on a rising clock edge, the whole start address is latched. From then on the two least significant address bits walk through the four words of the aligned block that holds the start address. The upper bits stay as they were captured.

Each sampled advance pulse moves the burst forward by one beat. Without advance, the address holds its value. A strap input chooses between two beat orders. In linear order the offset counts up and wraps at four. In interleaved order the offset is the start offset XOR the number of beats taken. The block holds only the captured base address and a two-bit beat counter.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high at a clock edge, the address output becomes all zeros and the beat count becomes zero.
- R2: When `load` is high at a clock edge, the output in the next cycle equals `addr_in` exactly, and the beat count restarts at zero.
- R3: When `load` and `advance` are both high at an edge, the load wins: the output equals `addr_in` and no beat is taken.
- R4: When `load` is low and `advance` is high at an edge, the beat count goes up by one modulo 4.
- R5: When `load` and `advance` are both low at an edge, the output keeps its previous value.
- R6: Output bits [16:2] always equal bits [16:2] of the most recently loaded address, whatever the number of advances.
- R7: With `mode` = 0 (linear), output bits [1:0] equal (start offset + beat count) mod 4.
- R8: With `mode` = 1 (interleaved), output bits [1:0] equal the start offset XOR the beat count.
- R9: After four advances the output returns to the loaded start address, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start a burst and capture `addr_in` |
| addr_in | input | 17 | Start address of the burst |
| advance | input | 1 | Step to the next beat |
| mode | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_out | output | 17 | Current memory address |

## Verification
The bench sweeps all four start offsets in both modes through eight advances, so it covers the wrap at four and the return to the start. A design that carried into bit 2 would change the upper bits. A design that mixed up the two orders would give the wrong beat sequence from every odd start offset.

The bench also drives load and advance together. A design that gives advance priority would come out one beat ahead. It holds advance low for stretches, where a design that stepped freely would drift.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int ADDR_W  = 17;
    localparam int BEAT_W  = 2;
    localparam int UPPER_W = ADDR_W - BEAT_W;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_INTLV  = 1'b1
    } order_e;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [BEAT_W-1:0]  start;
    } base_t;

    function automatic logic [BEAT_W-1:0] beat_offset(
        input order_e           ord,
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] cnt
    );
        if (ord == ORDER_INTLV)
            return start ^ cnt;
        else
            return start + cnt;
    endfunction
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_seq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] base_q
);
    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (load)
            base_q <= addr_in;
    end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
    import burst_seq_pkg::*;
#(
    parameter int BW = BEAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          advance,
    output logic [BW-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= '0;
        else if (advance)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              advance,
    input  logic              mode,
    output logic [ADDR_W-1:0] addr_out
);
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    base_t             base_s;
    order_e            ord;

    burst_base_reg #(.AW(ADDR_W)) u_base (
        .clk(clk), .rst(rst), .load(load), .addr_in(addr_in), .base_q(base_q)
    );

    burst_beat_cnt #(.BW(BEAT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .advance(advance), .cnt_q(cnt_q)
    );

    always_comb begin
        base_s   = base_t'(base_q);
        ord      = order_e'(mode);
        addr_out = {base_s.upper, beat_offset(ord, base_s.start, cnt_q)};
    end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic [ADDR_W-1:0] addr_in,
    input logic              advance,
    input logic              mode,
    input logic [ADDR_W-1:0] addr_out
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> addr_out == '0);

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> addr_out == $past(addr_in));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !load && !advance) |=> $stable(addr_out));

    assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !load) |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

    assert_linear_step_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !load && advance && !mode) |=>
            addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1));

    assert_step_moves_R4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !load && advance) |=> !$stable(addr_out[BEAT_W-1:0]));
endmodule

bind burst_addr_seq burst_addr_seq_chk u_chk (
    .clk(clk), .rst(rst), .load(load), .addr_in(addr_in),
    .advance(advance), .mode(mode), .addr_out(addr_out)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [16:0] addr_in = '0;
    logic        advance = 1'b0;
    logic        mode = 1'b0;
    logic [16:0] addr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2ns clk = ~clk;

    burst_addr_seq u_burst_addr_seq (
        .clk(clk), .rst(rst), .load(load), .addr_in(addr_in),
        .advance(advance), .mode(mode), .addr_out(addr_out)
    );

    task automatic check(input string req, input logic [16:0] exp);
        checks++;
        if (addr_out !== exp) begin
            fails++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    task automatic step(input logic l, input logic a, input logic [16:0] ad);
        load = l; advance = a; addr_in = ad;
        @(posedge clk);
        #1ns;
    endtask

    function automatic logic [16:0] expect_addr(input logic [16:0] base,
                                                input logic m, input int beats);
        logic [1:0] b;
        b = 2'(beats % 4);
        if (m) return {base[16:2], base[1:0] ^ b};
        else   return {base[16:2], 2'(base[1:0] + b)};
    endfunction

    initial begin
        #1ns;
        @(posedge clk); @(posedge clk); #1ns;
        check("R1", 17'h0);
        rst = 1'b0;

        for (int m = 0; m < 2; m++) begin
            mode = m[0];
            for (int s = 0; s < 4; s++) begin
                logic [16:0] base;
                base = {15'(17'h0ACE5 >> 2) ^ 15'(s * 4099 + m * 77), 2'(s)};
                step(1'b1, 1'b0, base);
                check("R2", base);
                for (int k = 1; k <= 8; k++) begin
                    step(1'b0, 1'b1, 17'h1FFFF);
                    check(m ? "R8" : "R7", expect_addr(base, m[0], k));
                    if (k == 4) check("R9", base);
                    if ((k % 4) == 2) begin
                        step(1'b0, 1'b0, 17'h0);
                        check("R5", expect_addr(base, m[0], k));
                    end
                end
                step(1'b1, 1'b1, ~base);
                check("R3", ~base);
                step(1'b0, 1'b1, base);
                check("R4", expect_addr(~base, m[0], 1));
                check("R6", {~base[16:2], addr_out[1:0]});
            end
        end

        step(1'b1, 1'b0, 17'h1FFFF);
        mode = 1'b0;
        step(1'b0, 1'b1, 17'h0);
        check("R6", 17'h1FFFC);
        check("R7", 17'h1FFFC);
        step(1'b0, 1'b0, 17'h0);
        rst = 1'b1;
        step(1'b0, 1'b0, 17'h0);
        check("R1", 17'h0);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule